// File: doc/BRIEF.md
# Multiplexed 16-bit external bus controller

This block runs one 16-bit read or write at a time to a slow external device. The device sits on two byte lanes, and each lane carries address and data at different times. A CPU-side request gives a 16-bit address, a low write byte, a read/write flag and two address-source selects. The controller then sequences the cycle. It drives an address latch enable pulse, then leaves a turnaround clock, then drives an active-low read or write strobe, then runs a final clock. At the end of the cycle it returns the read result with a one-clock done pulse.

The high data byte passes through a holding register. Software loads that register before a write. A read refills it with the high lane's value. The upper lane normally carries address bits 15:8 during the address phase. When the request is a short register-indirect access, or when page mode is on, the upper lane carries an external port-register value instead. A stretch input selects a long strobe for slow devices. The stretch input can change between cycles.

Top module: `ext16_bus_ctrl`

## Requirements
- R1: After reset, ale is 0, rdN and wrN are 1, loOe and hiOe are 0, done and busy are 0, and hiByte is 0.
- R2: A request is accepted on a rising edge where reqValid is 1 and busy is 0. In the next clock (cycle clock 0), ale is 1, busy is 1, both output enables are 1, and loOut equals reqAddr[7:0].
- R3: In cycle clock 0, hiOut equals the portReg value sampled at acceptance when reqShort or pageMode was 1. Otherwise hiOut equals reqAddr[15:8].
- R4: In cycle clock 1, ale is 0, both strobes are 1 and both output enables are 0, so the address is released before any strobe.
- R5: The strobe asserts in cycle clocks 2 onward. It stays low for 3 clocks when stretch was 0 at acceptance, and for 15 clocks when stretch was 1. rdN is used for reads (reqWrite=0) and wrN for writes (reqWrite=1).
- R6: A cycle lasts 6 clocks, or 18 when stretched. done is 1 only in the last cycle clock, and busy falls in the clock after done.
- R7: During a write, both lanes are enabled from the first WR clock through the last cycle clock. loOut carries reqLoData and hiOut carries the hiByte value held at acceptance.
- R8: During a read, both output enables are 0 while RD is low. loIn and hiIn are sampled on the last RD clock. From the done clock onward, rdData holds the loIn sample and hiByte holds the hiIn sample.
- R9: With no read capture on the same edge, hiWrEn=1 loads hiWrData into hiByte on the next rising edge.
- R10: A reqValid raised while busy is 1 has no effect. The running cycle keeps its type and length, and busy is 0 in the clock after done.
- R11: rdN and wrN are never 0 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request a transfer |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqShort | input | 1 | Register-indirect access; upper lane carries portReg |
| pageMode | input | 1 | Page mode; upper lane carries portReg |
| stretch | input | 1 | Long strobe for slow devices |
| reqAddr | input | 16 | Transfer address |
| reqLoData | input | 8 | Low write byte |
| portReg | input | 8 | Alternate upper-lane address byte |
| hiWrEn | input | 1 | Load the high-byte holding register |
| hiWrData | input | 8 | Value for the high-byte holding register |
| loIn | input | 8 | Low lane input from the pins |
| hiIn | input | 8 | High lane input from the pins |
| loOut | output | 8 | Low lane output value |
| loOe | output | 1 | Low lane output enable |
| hiOut | output | 8 | High lane output value |
| hiOe | output | 1 | High lane output enable |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| rdData | output | 8 | Low byte of the last read |
| hiByte | output | 8 | High-byte holding register |
| done | output | 1 | One-clock end-of-cycle pulse |
| busy | output | 1 | Cycle in progress |

## Verification
The hardest point to pin down from the ports is the exact clock on which read data is captured. The bench drives a different, arithmetically derived value onto each lane in every cycle clock. The returned bytes therefore identify which clock was sampled, in both normal and stretched cycles. A second hard case is a request that arrives mid-cycle with the opposite direction. The bench raises one during the turnaround clock and checks every following clock of the cycle for the original strobe type and length.

// File: rtl/ext16_pkg.sv
package ext16_pkg;
  parameter int LANE_W = 8;

  typedef struct packed {
    logic latchReq;
    logic addrPhase;
    logic rdStrobe;
    logic wrStrobe;
    logic wrDrive;
    logic capture;
  } ext16_strb_t;
endpackage

// File: rtl/ext16_ctrl.sv
module ext16_ctrl
  import ext16_pkg::*;
#(
  parameter int SHORT_STB = 3,
  parameter int LONG_STB  = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        stretch,
  output ext16_strb_t strb,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic        done,
  output logic        busy
);
  localparam int ALE_LEN   = 1;
  localparam int GAP_LEN   = 1;
  localparam int HOLD_LEN  = 1;
  localparam int STB_START = ALE_LEN + GAP_LEN;
  localparam int MAX_LEN   = STB_START + LONG_STB + HOLD_LEN;
  localparam int PH_W      = $clog2(MAX_LEN);

  logic            active;
  logic            stretchQ;
  logic            writeQ;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] stbLen;
  logic [PH_W-1:0] stbEnd;
  logic [PH_W-1:0] lastPh;
  logic            accept;
  logic            inStrobe;
  logic            holdPh;

  assign accept = reqValid && !active;
  assign stbLen = stretchQ ? PH_W'(LONG_STB) : PH_W'(SHORT_STB);
  assign stbEnd = PH_W'(STB_START) + stbLen;
  assign lastPh = stbEnd + PH_W'(HOLD_LEN - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      stretchQ <= 1'b0;
      writeQ   <= 1'b0;
      phase    <= '0;
    end else if (accept) begin
      active   <= 1'b1;
      stretchQ <= stretch;
      writeQ   <= reqWrite;
      phase    <= '0;
    end else if (active) begin
      if (phase == lastPh) begin
        active <= 1'b0;
        phase  <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    inStrobe      = active && (phase >= PH_W'(STB_START)) && (phase < stbEnd);
    holdPh        = active && (phase == lastPh);
    strb.latchReq  = accept;
    strb.addrPhase = active && (phase < PH_W'(ALE_LEN));
    strb.rdStrobe  = inStrobe && !writeQ;
    strb.wrStrobe  = inStrobe && writeQ;
    strb.wrDrive   = writeQ && (inStrobe || holdPh);
    strb.capture   = inStrobe && !writeQ && (phase == stbEnd - 1'b1);
  end

  assign ale  = strb.addrPhase;
  assign rdN  = !strb.rdStrobe;
  assign wrN  = !strb.wrStrobe;
  assign done = holdPh;
  assign busy = active;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(!rdN && !wrN)); // R11
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R6
  AST_BUSY_HOLD:   assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy); // R10
  AST_ALE_QUIET:   assert property (@(posedge clk) disable iff (!rstN) ale |=> (!ale && rdN && wrN)); // R4
  AST_DIR_STABLE:  assert property (@(posedge clk) disable iff (!rstN) (!rdN && !done) |=> wrN); // R10
endmodule

// File: rtl/ext16_dpath.sv
module ext16_dpath
  import ext16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ext16_strb_t       strb,
  input  logic              reqShort,
  input  logic              pageMode,
  input  logic [2*LANE_W-1:0] reqAddr,
  input  logic [LANE_W-1:0] reqLoData,
  input  logic [LANE_W-1:0] portReg,
  input  logic              hiWrEn,
  input  logic [LANE_W-1:0] hiWrData,
  input  logic [LANE_W-1:0] loIn,
  input  logic [LANE_W-1:0] hiIn,
  output logic [LANE_W-1:0] loOut,
  output logic              loOe,
  output logic [LANE_W-1:0] hiOut,
  output logic              hiOe,
  output logic [LANE_W-1:0] rdData,
  output logic [LANE_W-1:0] hiByte
);
  logic [LANE_W-1:0] loAddrQ;
  logic [LANE_W-1:0] hiAddrQ;
  logic [LANE_W-1:0] loDataQ;
  logic [LANE_W-1:0] hiDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loAddrQ <= '0;
      hiAddrQ <= '0;
      loDataQ <= '0;
      hiDataQ <= '0;
    end else if (strb.latchReq) begin
      loAddrQ <= reqAddr[LANE_W-1:0];
      hiAddrQ <= (reqShort || pageMode) ? portReg : reqAddr[2*LANE_W-1:LANE_W];
      loDataQ <= reqLoData;
      hiDataQ <= hiByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      hiByte <= '0;
    end else if (strb.capture) begin
      rdData <= loIn;
      hiByte <= hiIn;
    end else if (hiWrEn) begin
      hiByte <= hiWrData;
    end
  end

  assign loOe  = strb.addrPhase || strb.wrDrive;
  assign hiOe  = strb.addrPhase || strb.wrDrive;
  assign loOut = strb.addrPhase ? loAddrQ : loDataQ;
  assign hiOut = strb.addrPhase ? hiAddrQ : hiDataQ;

  AST_RD_LANES_OFF: assert property (@(posedge clk) disable iff (!rstN) strb.rdStrobe |-> (!loOe && !hiOe)); // R8
  AST_WR_LANES_ON:  assert property (@(posedge clk) disable iff (!rstN) strb.wrStrobe |=> (loOe && hiOe)); // R7
  AST_CAPTURE_SEEN: assert property (@(posedge clk) disable iff (!rstN) strb.capture |=> (rdData == $past(loIn) && hiByte == $past(hiIn))); // R8
endmodule

// File: rtl/ext16_bus_ctrl.sv
module ext16_bus_ctrl
  import ext16_pkg::*;
#(
  parameter int SHORT_STB = 3,
  parameter int LONG_STB  = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqShort,
  input  logic        pageMode,
  input  logic        stretch,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqLoData,
  input  logic [7:0]  portReg,
  input  logic        hiWrEn,
  input  logic [7:0]  hiWrData,
  input  logic [7:0]  loIn,
  input  logic [7:0]  hiIn,
  output logic [7:0]  loOut,
  output logic        loOe,
  output logic [7:0]  hiOut,
  output logic        hiOe,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic [7:0]  rdData,
  output logic [7:0]  hiByte,
  output logic        done,
  output logic        busy
);
  ext16_strb_t strb;

  ext16_ctrl #(.SHORT_STB(SHORT_STB), .LONG_STB(LONG_STB)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .stretch(stretch), .strb(strb), .ale(ale), .rdN(rdN), .wrN(wrN),
    .done(done), .busy(busy)
  );

  ext16_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqShort(reqShort),
    .pageMode(pageMode), .reqAddr(reqAddr), .reqLoData(reqLoData),
    .portReg(portReg), .hiWrEn(hiWrEn), .hiWrData(hiWrData),
    .loIn(loIn), .hiIn(hiIn), .loOut(loOut), .loOe(loOe),
    .hiOut(hiOut), .hiOe(hiOe), .rdData(rdData), .hiByte(hiByte)
  );
endmodule

// File: tb/tb_ext16_bus_ctrl.sv
`timescale 1ns/1ps
module tb_ext16_bus_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqShort = 1'b0, pageMode = 1'b0, stretch = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqLoData = '0, portReg = '0, hiWrData = '0, loIn = '0, hiIn = '0;
  logic hiWrEn = 1'b0;
  logic [7:0] loOut, hiOut, rdData, hiByte;
  logic loOe, hiOe, ale, rdN, wrN, done, busy;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [7:0] hiExp = '0;

  always #2 clk = ~clk;

  ext16_bus_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqShort(reqShort), .pageMode(pageMode), .stretch(stretch),
    .reqAddr(reqAddr), .reqLoData(reqLoData), .portReg(portReg),
    .hiWrEn(hiWrEn), .hiWrData(hiWrData), .loIn(loIn), .hiIn(hiIn),
    .loOut(loOut), .loOe(loOe), .hiOut(hiOut), .hiOe(hiOe), .ale(ale),
    .rdN(rdN), .wrN(wrN), .rdData(rdData), .hiByte(hiByte),
    .done(done), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setHi(input logic [7:0] v);
    @(negedge clk);
    hiWrEn = 1'b1;
    hiWrData = v;
    @(negedge clk);
    hiWrEn = 1'b0;
    hiExp = v;
    check("R9 hiByte load", 32'(hiByte), 32'(v));
  endtask

  task automatic runTxn(input logic wr, input logic st, input logic sh, input logic pg,
                        input logic [15:0] addr, input logic [7:0] acc, input logic [7:0] pv,
                        input logic [7:0] rb, input logic [7:0] hb, input logic inject);
    int len;
    int last;
    logic [7:0] expHi;
    logic [7:0] hiAtStart;
    len = st ? 15 : 3;
    last = len + 2;
    expHi = (sh || pg) ? pv : addr[15:8];
    hiAtStart = hiExp;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; stretch = st; reqShort = sh; pageMode = pg;
    reqAddr = addr; reqLoData = acc; portReg = pv;
    @(negedge clk);
    reqValid = 1'b0;
    // scramble select inputs: must not matter after acceptance
    stretch = ~st; portReg = ~pv; reqLoData = ~acc; reqAddr = ~addr;
    for (int ph = 0; ph <= last; ph++) begin
      logic stb;
      logic [6:0] expCtl;
      logic [7:0] expLo;
      logic [7:0] expHiRd;
      stb = (ph >= 2) && (ph < 2 + len);
      expCtl = {ph == 0, !(stb && !wr), !(stb && wr),
                (ph == 0) || (wr && ph >= 2), (ph == 0) || (wr && ph >= 2),
                ph == last, 1'b1};
      check("R4 R5 R6 R11 control pins", 32'({ale, rdN, wrN, loOe, hiOe, done, busy}), 32'(expCtl));
      if (ph == 0) begin
        check("R2 low lane address", 32'(loOut), 32'(addr[7:0]));
        check("R3 high lane address", 32'(hiOut), 32'(expHi));
      end
      if (wr && ph >= 2) begin
        check("R7 write low data", 32'(loOut), 32'(acc));
        check("R7 write high data", 32'(hiOut), 32'(hiAtStart));
      end
      if (!wr && ph == last) begin
        expLo = rb + 8'(last - 1);
        expHiRd = hb + 8'(2 * (last - 1));
        check("R8 read low byte", 32'(rdData), 32'(expLo));
        check("R8 read high byte", 32'(hiByte), 32'(expHiRd));
        hiExp = expHiRd;
      end
      loIn = rb + 8'(ph);
      hiIn = hb + 8'(2 * ph);
      if (inject && ph == 1) begin
        reqValid = 1'b1; reqWrite = !wr;
      end
      if (inject && ph == 3) reqValid = 1'b0;
      @(negedge clk);
    end
    check("R6 R10 idle after done", 32'({busy, done, ale, rdN, wrN}), 32'(5'b00011));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nFails++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    #1;
    check("R1 reset pins", 32'({ale, rdN, wrN, loOe, hiOe, done, busy}), 32'(7'b0110000));
    check("R1 reset hiByte", 32'(hiByte), 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'({ale, rdN, wrN, busy}), 32'(4'b0110));
    for (int st = 0; st < 2; st++)
      for (int wr = 0; wr < 2; wr++)
        for (int md = 0; md < 4; md++)
          for (int k = 0; k < 2; k++) begin
            logic [15:0] a;
            a = 16'h1357 * 16'(k + 1) + 16'(md * 16'h0421) + 16'(st * 16'h8000);
            if (wr == 1) setHi(8'h3C + 8'(md * 17) + 8'(k * 5));
            runTxn(wr[0], st[0], md[0], md[1], a, 8'hA0 + 8'(md * 3 + k),
                   8'h50 + 8'(md * 7), 8'h10 + 8'(md * 9 + k), 8'h80 + 8'(st * 11 + k),
                   k[0]);
          end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule